// File: doc/BRIEF.md
# Cascaded Interrupt Acknowledge Unit

This block joins two eight-line interrupt controllers into one sixteen-line interrupt source for a processor. The secondary controller serves lines 8 to 15. Its pending output feeds input 2 of the primary controller, so that input is not reachable from outside. Each controller keeps the previous level of every input, a request register, an in-service register, a mask register, a rotating lowest-priority pointer, a vector base and its end-of-interrupt mode bits. A decoded command port, driven by a separate register-write decoder, sets these.

When an unmasked request wins the rotating priority search and no equal or higher in-service line blocks it, the controller raises its pending flag. The primary flag drives `cpu_int`. The processor answers with a one-cycle `ack` pulse, which drops `cpu_int` in that same cycle. One clock later `vec` carries the vector and `vec_valid` is high. The vector is the primary base plus the line number. If the primary selected its cascade input, the vector is the secondary base plus the secondary line instead. The request and in-service registers are updated by the edge/level and automatic end-of-interrupt rules. Once the acknowledge is done, the search runs again, so further requests are raised in turn.

Top module: `pic_cascade_ack`

## Requirements
- R1: After reset the primary vector base is 0x08, the secondary base is 0x70, and both mask registers are 0xFF. `cpu_int` and `vec_valid` are low. A request raised while masked does not assert `cpu_int`.
- R2: A line that goes from low to high records one request. A line held high records no further request. A line that falls clears its request.
- R3: Priority is checked starting from the line after the lowest-priority pointer (pointer 7 after reset, giving order 0,1,…,7). The first in-service line met blocks itself and every line after it. The first unmasked request met before that point asserts `cpu_int`.
- R4: `cpu_int` is low in the cycle in which `ack` is high. `vec_valid` is high for exactly the cycle after each `ack`, and `vec` then equals {base[7:3], line[2:0]}.
- R5: If the primary request register is zero when `ack` arrives, the vector is the primary base + 7. The pending flag clears, and neither the in-service register nor the pointer changes.
- R6: On acknowledge, the request bit of the served line clears if `level_mode` for that line is 0 (edge) and stays set if it is 1 (level). A level request is therefore raised again after its end of interrupt.
- R7: With automatic end of interrupt (mode data bit 0 = 1), an acknowledge sets no in-service bit. If rotation on automatic end of interrupt is also on (mode data bit 1 = 1), the pointer becomes the served line.
- R8: Lines 8 to 15 reach the processor through primary input 2, and their vector is the secondary base + (line − 8). `irq_in[2]` and `level_mode[2]` have no effect.
- R9: If the primary served input 2 and the secondary request register is zero, the vector is the secondary base + 7.
- R10: Commands (`cmd_sel` 0 = primary, 1 = secondary), with `cmd_op` codes:
  - 0 initialise: clears request, in-service and mask registers and the pending flag, sets the pointer to 7 and clears both mode bits.
  - 1 mask: writes the mask register from `cmd_data`.
  - 2 base: writes the base from `cmd_data[7:3]`.
  - 3 mode: sets the mode bits from `cmd_data[1:0]`.
  - 4 specific end of interrupt: clears in-service bit `cmd_data[2:0]`.
  - 5 non-specific end of interrupt: clears the in-service bit that has the highest priority.
  - 6 pointer: sets the pointer to `cmd_data[2:0]`.
  - 7 is ignored.
- R11: Initialising the secondary controller drops any request held on primary input 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| irq_in | input | 16 | Interrupt lines; bit 2 unused |
| level_mode | input | 16 | Per line: 1 = level, 0 = edge; bit 2 unused |
| cmd_valid | input | 1 | Decoded command strobe |
| cmd_sel | input | 1 | 0 primary, 1 secondary |
| cmd_op | input | 3 | Command code (R10) |
| cmd_data | input | 8 | Command operand |
| ack | input | 1 | One-cycle acknowledge from the processor |
| cpu_int | output | 1 | Interrupt request to the processor |
| vec_valid | output | 1 | Vector valid, one cycle after `ack` |
| vec | output | 8 | Interrupt vector |

## Verification
The assertions check on every cycle that the vector strobe follows `ack` exactly, that an acknowledge clears the pending flag, that rising and falling inputs update the request register as R2 says, and that an acknowledge sets or leaves the in-service bit according to the automatic end-of-interrupt mode. Only the bench scenarios can show the orderings and outcomes across several steps. These include in-service blocking and its release by both kinds of end of interrupt, pointer rotation choosing between simultaneous requests, spurious vectors from either controller, the re-raise of a level request, vectors routed through the cascade, and the effect of initialisation on the cascade input.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int LINES = 8;
  localparam int LW    = $clog2(LINES);
  localparam int BW    = 8 - LW;

  typedef enum logic [2:0] {
    OP_INIT    = 3'd0,
    OP_MASK    = 3'd1,
    OP_BASE    = 3'd2,
    OP_MODE    = 3'd3,
    OP_EOI_SPC = 3'd4,
    OP_EOI_TOP = 3'd5,
    OP_LOWEST  = 3'd6,
    OP_NONE    = 3'd7
  } cmd_op_e;

  typedef struct packed {
    logic          found;
    logic [LW-1:0] line;
  } pick_t;

  // Rotating search: start after the lowest-priority line; a blocking bit
  // stops the search, a request bit ends it with a hit.
  function automatic pick_t pick_next(logic [LINES-1:0] req,
                                      logic [LINES-1:0] blk,
                                      logic [LW-1:0]    lowest);
    pick_t         r;
    logic          done;
    logic [LW-1:0] idx;
    r    = '0;
    done = 1'b0;
    for (int i = 0; i < LINES; i++) begin
      idx = lowest + LW'(1) + LW'(i);
      if (!done) begin
        if (blk[idx]) begin
          done = 1'b1;
        end else if (req[idx]) begin
          r.found = 1'b1;
          r.line  = idx;
          done    = 1'b1;
        end
      end
    end
    return r;
  endfunction

  function automatic logic [7:0] make_vec(logic [BW-1:0] base, logic [LW-1:0] line);
    return {base, line};
  endfunction
endpackage

// File: rtl/pic_edge_latch.sv
module pic_edge_latch
  import pic_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] lines,
  input  logic [LINES-1:0] drop,
  output logic [LINES-1:0] rise,
  output logic [LINES-1:0] fall
);
  for (genvar i = 0; i < LINES; i++) begin : g_bit
    logic prev_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= lines[i] & ~drop[i];
    end
    assign rise[i] = lines[i] & ~prev_q;
    assign fall[i] = ~lines[i] & prev_q;
  end
endmodule

// File: rtl/pic_prio_pick.sv
module pic_prio_pick
  import pic_pkg::*;
(
  input  logic [LINES-1:0] req,
  input  logic [LINES-1:0] blk,
  input  logic [LW-1:0]    lowest,
  output logic             found,
  output logic [LW-1:0]    line
);
  pick_t res;
  always_comb res = pick_next(req, blk, lowest);
  assign found = res.found;
  assign line  = res.line;
endmodule

// File: rtl/pic_unit.sv
module pic_unit
  import pic_pkg::*;
#(
  parameter logic [7:0] RESET_BASE = 8'h08
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] lines,
  input  logic [LINES-1:0] level,
  input  logic             cmd_hit,
  input  logic [2:0]       cmd_op,
  input  logic [7:0]       cmd_data,
  input  logic             ack_req,
  input  logic             clr_pend,
  input  logic [LINES-1:0] drop,
  output logic             pend,
  output logic [LW-1:0]    cur,
  output logic             irr_zero,
  output logic [BW-1:0]    base
);
  logic [LINES-1:0] irr, isr, imr;
  logic [LW-1:0]    lowest;
  logic             aeoi, raeoi;

  logic [LINES-1:0] irr_n, isr_n, imr_n;
  logic [LW-1:0]    lowest_n, cur_n;
  logic [BW-1:0]    base_n;
  logic             aeoi_n, raeoi_n, pend_n;

  logic [LINES-1:0] edge_rise, edge_fall;
  logic             pick_found, top_found;
  logic [LW-1:0]    pick_line, top_line;
  logic             ack_take;
  logic             is_init;

  pic_edge_latch u_latch (
    .clk   (clk),
    .rst_n (rst_n),
    .lines (lines),
    .drop  (drop),
    .rise  (edge_rise),
    .fall  (edge_fall)
  );

  // Request search over unmasked requests, blocked by in-service lines.
  pic_prio_pick u_pick (
    .req    (irr & ~imr),
    .blk    (isr),
    .lowest (lowest),
    .found  (pick_found),
    .line   (pick_line)
  );

  // Highest-priority in-service line for the non-specific end of interrupt.
  pic_prio_pick u_top (
    .req    (isr),
    .blk    ('0),
    .lowest (lowest),
    .found  (top_found),
    .line   (top_line)
  );

  assign irr_zero = (irr == '0);
  assign ack_take = ack_req & ~irr_zero;
  assign is_init  = cmd_hit & (cmd_op == OP_INIT);

  always_comb begin
    irr_n    = (irr | edge_rise) & ~edge_fall & ~drop;
    isr_n    = isr;
    imr_n    = imr;
    base_n   = base;
    lowest_n = lowest;
    aeoi_n   = aeoi;
    raeoi_n  = raeoi;
    pend_n   = pend;
    cur_n    = cur;

    if (cmd_hit) begin
      unique case (cmd_op)
        OP_MASK:    imr_n = cmd_data;
        OP_BASE:    base_n = cmd_data[7:LW];
        OP_MODE:    begin aeoi_n = cmd_data[0]; raeoi_n = cmd_data[1]; end
        OP_EOI_SPC: isr_n[cmd_data[LW-1:0]] = 1'b0;
        OP_EOI_TOP: if (top_found) isr_n[top_line] = 1'b0;
        OP_LOWEST:  lowest_n = cmd_data[LW-1:0];
        default:    ;
      endcase
    end

    if (ack_take) begin
      if (!level[cur]) irr_n[cur] = 1'b0;
      if (!aeoi)       isr_n[cur] = 1'b1;
      else if (raeoi)  lowest_n   = cur;
    end

    if (clr_pend) begin
      pend_n = 1'b0;
    end else if (!pend && pick_found) begin
      pend_n = 1'b1;
      cur_n  = pick_line;
    end

    if (is_init) begin
      irr_n    = '0;
      isr_n    = '0;
      imr_n    = '0;
      lowest_n = LW'(LINES - 1);
      pend_n   = 1'b0;
      aeoi_n   = 1'b0;
      raeoi_n  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irr    <= '0;
      isr    <= '0;
      imr    <= '1;
      base   <= RESET_BASE[7:LW];
      lowest <= LW'(LINES - 1);
      aeoi   <= 1'b0;
      raeoi  <= 1'b0;
      pend   <= 1'b0;
      cur    <= '0;
    end else begin
      irr    <= irr_n;
      isr    <= isr_n;
      imr    <= imr_n;
      base   <= base_n;
      lowest <= lowest_n;
      aeoi   <= aeoi_n;
      raeoi  <= raeoi_n;
      pend   <= pend_n;
      cur    <= cur_n;
    end
  end

  assert_pend_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    clr_pend |=> !pend);

  assert_isr_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_take && !aeoi && !cmd_hit) |=> isr[$past(cur)]);

  assert_aeoi_no_isr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_take && aeoi && !cmd_hit && !isr[cur]) |=> !isr[$past(cur)]);

  assert_rise_latch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_hit && !ack_take && ((edge_rise & ~drop) != '0))
      |=> ((irr & $past(edge_rise & ~drop)) == $past(edge_rise & ~drop)));

  assert_fall_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_fall != '0) |=> ((irr & $past(edge_fall)) == '0));
endmodule

// File: rtl/pic_cascade_ack.sv
module pic_cascade_ack
  import pic_pkg::*;
#(
  parameter logic [7:0] PRI_BASE     = 8'h08,
  parameter logic [7:0] SEC_BASE     = 8'h70,
  parameter int         CASCADE_LINE = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] irq_in,
  input  logic [15:0] level_mode,
  input  logic        cmd_valid,
  input  logic        cmd_sel,
  input  logic [2:0]  cmd_op,
  input  logic [7:0]  cmd_data,
  input  logic        ack,
  output logic        cpu_int,
  output logic        vec_valid,
  output logic [7:0]  vec
);
  localparam logic [LINES-1:0] CASC_BIT = LINES'(1) << CASCADE_LINE;

  logic             p_pend, s_pend;
  logic [LW-1:0]    p_cur, s_cur;
  logic             p_irr_zero, s_irr_zero;
  logic [BW-1:0]    p_base, s_base;
  logic [LINES-1:0] p_lines, p_level, p_drop;
  logic             casc_ack, s_init;
  logic [7:0]       vec_n;
  logic             unused_bits;

  assign unused_bits = ^{irq_in[CASCADE_LINE], level_mode[CASCADE_LINE]};

  // Primary input at the cascade position is the secondary pending flag.
  always_comb begin
    p_lines = irq_in[LINES-1:0];
    p_lines[CASCADE_LINE] = s_pend;
    p_level = level_mode[LINES-1:0] & ~CASC_BIT;
  end

  assign casc_ack = ack & ~p_irr_zero & (p_cur == LW'(CASCADE_LINE));
  assign s_init   = cmd_valid & cmd_sel & (cmd_op == OP_INIT);
  assign p_drop   = (casc_ack | s_init) ? CASC_BIT : '0;

  pic_unit #(.RESET_BASE(PRI_BASE)) u_pri (
    .clk      (clk),
    .rst_n    (rst_n),
    .lines    (p_lines),
    .level    (p_level),
    .cmd_hit  (cmd_valid & ~cmd_sel),
    .cmd_op   (cmd_op),
    .cmd_data (cmd_data),
    .ack_req  (ack),
    .clr_pend (ack),
    .drop     (p_drop),
    .pend     (p_pend),
    .cur      (p_cur),
    .irr_zero (p_irr_zero),
    .base     (p_base)
  );

  pic_unit #(.RESET_BASE(SEC_BASE)) u_sec (
    .clk      (clk),
    .rst_n    (rst_n),
    .lines    (irq_in[2*LINES-1:LINES]),
    .level    (level_mode[2*LINES-1:LINES]),
    .cmd_hit  (cmd_valid & cmd_sel),
    .cmd_op   (cmd_op),
    .cmd_data (cmd_data),
    .ack_req  (casc_ack),
    .clr_pend (casc_ack),
    .drop     ('0),
    .pend     (s_pend),
    .cur      (s_cur),
    .irr_zero (s_irr_zero),
    .base     (s_base)
  );

  assign cpu_int = p_pend & ~ack;

  always_comb begin
    if (p_irr_zero)       vec_n = make_vec(p_base, LW'(LINES - 1));
    else if (!casc_ack)   vec_n = make_vec(p_base, p_cur);
    else if (s_irr_zero)  vec_n = make_vec(s_base, LW'(LINES - 1));
    else                  vec_n = make_vec(s_base, s_cur);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_valid <= 1'b0;
      vec       <= '0;
    end else begin
      vec_valid <= ack;
      if (ack) vec <= vec_n;
    end
  end

  assert_vec_follows_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> vec_valid);

  assert_vec_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !ack |=> !vec_valid);

  assert_casc_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    casc_ack |=> !s_pend);
endmodule

// File: tb/pic_cascade_ack_test.sv
module pic_cascade_ack_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] irq_in = '0;
  logic [15:0] level_mode = '0;
  logic        cmd_valid = 1'b0;
  logic        cmd_sel = 1'b0;
  logic [2:0]  cmd_op = 3'd7;
  logic [7:0]  cmd_data = '0;
  logic        ack = 1'b0;
  logic        cpu_int, vec_valid;
  logic [7:0]  vec;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2.5 clk = ~clk;

  pic_cascade_ack uut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .level_mode(level_mode),
    .cmd_valid(cmd_valid), .cmd_sel(cmd_sel), .cmd_op(cmd_op), .cmd_data(cmd_data),
    .ack(ack), .cpu_int(cpu_int), .vec_valid(vec_valid), .vec(vec)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cmd(logic sel, logic [2:0] op, logic [7:0] data);
    cmd_valid = 1'b1; cmd_sel = sel; cmd_op = op; cmd_data = data;
    step(1);
    cmd_valid = 1'b0; cmd_op = 3'd7;
  endtask

  task automatic wait_int(string req);
    for (int i = 0; i < 20 && !cpu_int; i++) step(1);
    chk(req, {7'd0, cpu_int}, 8'd1);
  endtask

  task automatic do_ack(logic [7:0] exp, string req);
    exp_q.push_back(exp);
    tag_q.push_back(req);
    ack = 1'b1;
    #1 chk({req, " int low during ack"}, {7'd0, cpu_int}, 8'd0);
    step(1);
    ack = 1'b0;
    step(1);
  endtask

  // Scoreboard monitor: compares each produced vector with the queue head.
  always @(negedge clk) begin
    if (rst_n && vec_valid) begin
      if (exp_q.size() == 0) begin
        chk("R4 unexpected vector", vec, 8'hxx);
      end else begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        chk(t, vec, e);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    chk("R1 reset int", {7'd0, cpu_int}, 8'd0);
    chk("R1 reset vec_valid", {7'd0, vec_valid}, 8'd0);

    // R1 masked after reset, then base 0x08
    irq_in[3] = 1'b1; step(4);
    chk("R1 masked request", {7'd0, cpu_int}, 8'd0);
    cmd(0, 3'd1, 8'h00);
    wait_int("R3 unmasked raise");
    do_ack(8'h0B, "R4 R1 primary base vector");

    // R3 in-service blocking, R10 end of interrupt, R6 edge
    irq_in[5] = 1'b1; step(4);
    chk("R3 lower priority blocked", {7'd0, cpu_int}, 8'd0);
    irq_in[1] = 1'b1;
    wait_int("R3 higher priority passes");
    do_ack(8'h09, "R3 vector line 1");
    cmd(0, 3'd5, 8'h00); step(4);
    chk("R10 non-specific eoi clears top only", {7'd0, cpu_int}, 8'd0);
    cmd(0, 3'd4, 8'h03);
    wait_int("R10 specific eoi releases");
    do_ack(8'h0D, "R3 vector line 5");
    cmd(0, 3'd4, 8'h05); step(4);
    chk("R6 R2 held edge line no re-request", {7'd0, cpu_int}, 8'd0);
    irq_in[1] = 1'b0; irq_in[3] = 1'b0; irq_in[5] = 1'b0; step(2);

    // R5 spurious on primary
    irq_in[6] = 1'b1;
    wait_int("R5 raise");
    irq_in[6] = 1'b0; step(3);
    chk("R5 pending kept after drop", {7'd0, cpu_int}, 8'd1);
    do_ack(8'h0F, "R5 spurious primary");
    irq_in[6] = 1'b1;
    wait_int("R5 no in-service set by spurious");
    do_ack(8'h0E, "R5 line 6 after spurious");
    cmd(0, 3'd4, 8'h06); irq_in[6] = 1'b0; step(2);

    // R6 level mode
    level_mode[4] = 1'b1; irq_in[4] = 1'b1;
    wait_int("R6 level raise");
    do_ack(8'h0C, "R6 level vector");
    cmd(0, 3'd4, 8'h04);
    wait_int("R6 level re-raise after eoi");
    do_ack(8'h0C, "R6 level second vector");
    irq_in[4] = 1'b0; step(2);
    cmd(0, 3'd4, 8'h04); level_mode[4] = 1'b0; step(3);

    // R7 automatic end of interrupt and rotation
    cmd(0, 3'd3, 8'h01);
    irq_in[1] = 1'b1;
    wait_int("R7 aeoi raise");
    do_ack(8'h09, "R7 aeoi vector");
    irq_in[1] = 1'b0; irq_in[6] = 1'b1;
    wait_int("R7 no in-service in aeoi");
    do_ack(8'h0E, "R7 aeoi second vector");
    irq_in[6] = 1'b0;
    cmd(0, 3'd3, 8'h03);
    irq_in[4] = 1'b1;
    wait_int("R7 rotate raise");
    do_ack(8'h0C, "R7 rotate vector");
    irq_in[4] = 1'b0; step(2);
    irq_in[0] = 1'b1; irq_in[5] = 1'b1;
    wait_int("R7 rotated raise");
    do_ack(8'h0D, "R7 rotated order picks 5");
    wait_int("R7 next");
    do_ack(8'h08, "R7 rotated order then 0");
    irq_in[0] = 1'b0; irq_in[5] = 1'b0;
    cmd(0, 3'd3, 8'h00);
    cmd(0, 3'd6, 8'h07); step(2);

    // R10 pointer command
    cmd(0, 3'd6, 8'h02);
    irq_in[1] = 1'b1; irq_in[3] = 1'b1;
    wait_int("R10 pointer raise");
    do_ack(8'h0B, "R10 pointer 2 favours line 3");
    cmd(0, 3'd6, 8'h07);
    wait_int("R10 pointer 7 favours line 1");
    do_ack(8'h09, "R10 line 1 after pointer reset");
    cmd(0, 3'd4, 8'h01); cmd(0, 3'd4, 8'h03);
    irq_in[1] = 1'b0; irq_in[3] = 1'b0; step(2);

    // R8 cascade
    cmd(1, 3'd1, 8'h00);
    irq_in[10] = 1'b1;
    wait_int("R8 cascade raise");
    do_ack(8'h72, "R8 cascade vector");
    cmd(0, 3'd4, 8'h02); cmd(1, 3'd4, 8'h02);
    irq_in[10] = 1'b0;
    irq_in[2] = 1'b1; level_mode[2] = 1'b1; step(6);
    chk("R8 input 2 ignored", {7'd0, cpu_int}, 8'd0);
    irq_in[2] = 1'b0; level_mode[2] = 1'b0; step(2);

    // R9 secondary spurious
    irq_in[12] = 1'b1;
    wait_int("R9 raise");
    irq_in[12] = 1'b0; step(3);
    do_ack(8'h77, "R9 spurious secondary");
    cmd(0, 3'd4, 8'h02); step(2);

    // R10 base writes
    cmd(0, 3'd2, 8'h27);
    irq_in[3] = 1'b1;
    wait_int("R10 base raise");
    do_ack(8'h23, "R10 primary base write");
    cmd(0, 3'd4, 8'h03); irq_in[3] = 1'b0;
    cmd(1, 3'd2, 8'h48);
    irq_in[13] = 1'b1;
    wait_int("R10 secondary base raise");
    do_ack(8'h4D, "R10 secondary base write");
    cmd(0, 3'd4, 8'h02); cmd(1, 3'd4, 8'h05); irq_in[13] = 1'b0; step(2);

    // R11 secondary init drops cascade request
    cmd(0, 3'd1, 8'h04);
    irq_in[9] = 1'b1; step(8);
    chk("R11 cascade masked", {7'd0, cpu_int}, 8'd0);
    cmd(1, 3'd0, 8'h00); step(2);
    cmd(0, 3'd1, 8'h00); step(6);
    chk("R11 cascade request dropped", {7'd0, cpu_int}, 8'd0);
    irq_in[9] = 1'b0; step(2);

    // R10 primary init
    irq_in[1] = 1'b1;
    wait_int("R10 init raise");
    cmd(0, 3'd0, 8'h00); step(1);
    chk("R10 init clears pending", {7'd0, cpu_int}, 8'd0);
    step(4);
    chk("R10 init clears requests", {7'd0, cpu_int}, 8'd0);
    irq_in[1] = 1'b0; step(3);

    chk("R4 all vectors produced", 8'(exp_q.size()), 8'd0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule